// File: doc/BRIEF.md
# De-interlacing vertical sync sampler

This block turns a vertical sync input into a clean vertical reset pulse for a line-locked deflection timing chain. A position counter restarts on every horizontal sync leading edge (rising edge). In gated mode the vertical sync level is captured once per line, at one of two positions exactly half a line apart. Choosing between the two positions moves the detected field start by half a line, so an interlaced source can be de-interlaced in either direction. In direct mode the chosen edge of vertical sync is taken on the system clock and used as the reset.

A field line counter counts horizontal sync leading edges since the last vertical reset. It enforces a lock range: a vertical sync that comes too early in a field is discarded and flagged. A field that runs too long without a usable sync is ended by an internally generated reset, which is also flagged. All counts and positions are parameters. The defaults are a 432-clock line, sampling positions 42 and 258, a 200-line minimum and a 910-line maximum.

Top module: `vdeint_sampler`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `vreset_o` is 0, `field_line_o` is 0 and `range_err_o` is 0.
- R2: With `deint_off`=0 and `phase_late`=0, the active vertical level is captured at the clock edge that comes EARLY (42) edges after the edge that detects the horizontal rising edge. A level driven active before that sampling edge counts. `vreset_o` is high in the cycle after the sampling edge.
- R3: With `deint_off`=0 and `phase_late`=1, the same capture takes place LATE (258) edges after the detecting edge, which is half of a LINE_CLKS line later than R2.
- R4: In gated mode a reset comes only from the first sample that is active after a sample that was inactive. A vertical pulse that stays active over several lines gives exactly one reset.
- R5: With `deint_off`=1, the clock edge on which the active vertical edge is first seen is followed by a `vreset_o` cycle.
- R6: `edge_neg`=0 makes the rising vertical edge active (active level high). `edge_neg`=1 makes the falling edge active (active level low). The opposite edge never produces a reset.
- R7: `field_line_o` rises by one on each horizontal rising edge and becomes 0 on every reset. A vertical trigger that is accepted on the same edge as a horizontal rising edge takes priority, so the count is 0.
- R8: A vertical trigger that arrives while `field_line_o` is below MIN_LINES (200) is discarded with no reset, and `range_err_o` becomes 1. A trigger at exactly MIN_LINES is accepted.
- R9: If no trigger is accepted, the horizontal rising edge that would make the count MAX_LINES (910) instead produces a reset pulse, sets the count to 0 and sets `range_err_o` to 1.
- R10: An accepted vertical trigger clears `range_err_o` on the same edge that raises `vreset_o`.
- R11: `vreset_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, line locked |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync, rising edge is the leading edge |
| vsync_in | input | 1 | Vertical sync |
| deint_off | input | 1 | 0: gated sampling mode, 1: direct edge mode |
| phase_late | input | 1 | Gated mode sampling position: 0 early, 1 late |
| edge_neg | input | 1 | 0: rising vertical edge active, 1: falling |
| vreset_o | output | 1 | One-clock vertical reset pulse |
| field_line_o | output | $clog2(MAX_LINES) | Lines since last vertical reset |
| range_err_o | output | 1 | Field ended outside the lock range |

## Verification
The bench sweeps the vertical edge across every clock position of the line, for both sampling positions and both polarities. A sampler that is off by one clock, or that uses the wrong offset, shows up at the positions on either side of the sampling point. A design that fires on the release edge, or that fires again on each active line of a long pulse, fails the one-event count per case. The lock-range checks put triggers one line below and exactly at the minimum. They also let a field run to the maximum length. A wrong comparison bound, a missing free-run reset, or a flag that never clears gives a wrong event count or a wrong flag value there.

// File: rtl/vdeint_pkg.sv
package vdeint_pkg;

    localparam int DEF_LINE_CLKS = 432;
    localparam int DEF_EARLY     = 42;
    localparam int DEF_LATE      = 258;
    localparam int DEF_MIN_LINES = 200;
    localparam int DEF_MAX_LINES = 910;

    typedef enum logic {
        SAMPLE_GATED = 1'b0,
        EDGE_DIRECT  = 1'b1
    } vmode_e;

    typedef struct packed {
        logic accept;
        logic reject;
        logic wrap;
    } field_cmd_t;

    function automatic logic active_level(input logic raw, input logic neg);
        return raw ^ neg;
    endfunction

endpackage

// File: rtl/hline_timer.sv
module hline_timer #(
    parameter int LINE_CLKS = 432,
    parameter int POS_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync,
    output logic             hs_lead,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] POS_SAT = POS_W'(LINE_CLKS);

    logic hs_q;

    assign hs_lead = hsync && !hs_q;

    // pos counts edges since the detecting edge; it saturates so that
    // each sampling position can match only once per line
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            pos  <= POS_SAT;
        end else begin
            hs_q <= hsync;
            if (hs_lead)
                pos <= POS_W'(1);
            else if (pos != POS_SAT)
                pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/vsync_trigger.sv
module vsync_trigger
    import vdeint_pkg::*;
#(
    parameter int EARLY = 42,
    parameter int LATE  = 258,
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync,
    input  logic             edge_neg,
    input  vmode_e           mode,
    input  logic             phase_late,
    input  logic [POS_W-1:0] pos,
    output logic             trig
);
    localparam logic [POS_W-1:0] OFF_E = POS_W'(EARLY);
    localparam logic [POS_W-1:0] OFF_L = POS_W'(LATE);

    logic             vs_q;
    logic             samp_q;
    logic             act_now;
    logic             act_prev;
    logic             at_samp;
    logic [POS_W-1:0] off;

    always_comb begin
        off      = phase_late ? OFF_L : OFF_E;
        at_samp  = (pos == off);
        act_now  = active_level(vsync, edge_neg);
        act_prev = active_level(vs_q, edge_neg);
        case (mode)
            SAMPLE_GATED: trig = at_samp && act_now && !samp_q;
            default:      trig = act_now && !act_prev;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            samp_q <= 1'b0;
        end else begin
            vs_q <= vsync;
            if (at_samp)
                samp_q <= act_now;
        end
    end
endmodule

// File: rtl/field_tracker.sv
module field_tracker
    import vdeint_pkg::*;
#(
    parameter int MIN_LINES = 200,
    parameter int MAX_LINES = 910,
    parameter int LN_W      = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hs_lead,
    input  logic            trig,
    output logic            vreset,
    output logic [LN_W-1:0] cnt,
    output logic            flag
);
    localparam logic [LN_W-1:0] MIN_L  = LN_W'(MIN_LINES);
    localparam logic [LN_W-1:0] LAST_L = LN_W'(MAX_LINES - 1);

    field_cmd_t cmd;

    always_comb begin
        cmd.accept = trig && (cnt >= MIN_L);
        cmd.reject = trig && (cnt < MIN_L);
        cmd.wrap   = hs_lead && (cnt == LAST_L) && !cmd.accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vreset <= 1'b0;
            cnt    <= '0;
            flag   <= 1'b0;
        end else begin
            vreset <= cmd.accept || cmd.wrap;
            if (cmd.accept) begin
                cnt  <= '0;
                flag <= 1'b0;
            end else if (cmd.wrap) begin
                cnt  <= '0;
                flag <= 1'b1;
            end else begin
                if (cmd.reject)
                    flag <= 1'b1;
                if (hs_lead)
                    cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vdeint_sampler.sv
module vdeint_sampler
    import vdeint_pkg::*;
#(
    parameter int LINE_CLKS  = DEF_LINE_CLKS,
    parameter int EARLY      = DEF_EARLY,
    parameter int LATE       = DEF_LATE,
    parameter int MIN_LINES  = DEF_MIN_LINES,
    parameter int MAX_LINES  = DEF_MAX_LINES,
    localparam int LN_W      = $clog2(MAX_LINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hsync_in,
    input  logic            vsync_in,
    input  logic            deint_off,
    input  logic            phase_late,
    input  logic            edge_neg,
    output logic            vreset_o,
    output logic [LN_W-1:0] field_line_o,
    output logic            range_err_o
);
    localparam int POS_W = $clog2(LINE_CLKS + 1);

    logic             hs_lead;
    logic [POS_W-1:0] pos;
    logic             trig;

    hline_timer #(.LINE_CLKS(LINE_CLKS), .POS_W(POS_W)) u_line (
        .clk    (clk),
        .rst    (rst),
        .hsync  (hsync_in),
        .hs_lead(hs_lead),
        .pos    (pos)
    );

    vsync_trigger #(.EARLY(EARLY), .LATE(LATE), .POS_W(POS_W)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync_in),
        .edge_neg  (edge_neg),
        .mode      (vmode_e'(deint_off)),
        .phase_late(phase_late),
        .pos       (pos),
        .trig      (trig)
    );

    field_tracker #(.MIN_LINES(MIN_LINES), .MAX_LINES(MAX_LINES), .LN_W(LN_W)) u_field (
        .clk    (clk),
        .rst    (rst),
        .hs_lead(hs_lead),
        .trig   (trig),
        .vreset (vreset_o),
        .cnt    (field_line_o),
        .flag   (range_err_o)
    );
endmodule

// File: rtl/vdeint_sampler_chk.sv
module vdeint_sampler_chk #(
    parameter int MIN_LINES = 200,
    parameter int MAX_LINES = 910,
    localparam int LN_W     = $clog2(MAX_LINES)
) (
    input logic            clk,
    input logic            rst,
    input logic            vreset_o,
    input logic [LN_W-1:0] field_line_o,
    input logic            range_err_o
);
    localparam logic [LN_W-1:0] MIN_L  = LN_W'(MIN_LINES);
    localparam logic [LN_W-1:0] LAST_L = LN_W'(MAX_LINES - 1);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        vreset_o |=> !vreset_o);

    p_count_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        vreset_o |-> field_line_o == '0);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        field_line_o <= LAST_L);

    p_flag_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(range_err_o) |-> (vreset_o || $past(field_line_o) < MIN_L));

    p_flag_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(range_err_o) |-> vreset_o);
endmodule

bind vdeint_sampler vdeint_sampler_chk #(
    .MIN_LINES(MIN_LINES),
    .MAX_LINES(MAX_LINES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vreset_o    (vreset_o),
    .field_line_o(field_line_o),
    .range_err_o (range_err_o)
);

// File: tb/sim_vdeint_sampler.sv
module sim_vdeint_sampler;
    localparam int CLK_NS = 10;
    localparam int LINE   = 16;
    localparam int EARLY  = 2;
    localparam int LATE   = 10;
    localparam int MINL   = 4;
    localparam int MAXL   = 12;
    localparam int LW     = $clog2(MAXL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync = 1'b0;
    logic vsync = 1'b0;
    logic deint_off = 1'b0;
    logic phase_late = 1'b0;
    logic edge_neg = 1'b0;
    logic          vreset_o;
    logic [LW-1:0] field_line_o;
    logic          range_err_o;

    int tcyc = 0;
    int ev_n = 0;
    int ev_t = -1;
    int total = 0;
    int bad = 0;

    vdeint_sampler #(.LINE_CLKS(LINE), .EARLY(EARLY), .LATE(LATE),
                     .MIN_LINES(MINL), .MAX_LINES(MAXL)) u0 (
        .clk(clk), .rst(rst), .hsync_in(hsync), .vsync_in(vsync),
        .deint_off(deint_off), .phase_late(phase_late), .edge_neg(edge_neg),
        .vreset_o(vreset_o), .field_line_o(field_line_o), .range_err_o(range_err_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) tcyc <= tcyc + 1;

    // event time = number of the edge that raised the pulse
    always @(negedge clk) if (!rst && vreset_o) begin
        ev_n++;
        ev_t = tcyc;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic line(input int c1, input logic v1, input int c2, input logic v2,
                        output int ls);
        ls = 0;
        for (int j = 0; j < LINE; j++) begin
            @(negedge clk);
            if (j == 0) ls = tcyc + 1;
            hsync = (j < 2);
            if (j == c1) vsync = v1;
            if (j == c2) vsync = v2;
        end
    endtask

    task automatic idle(input int n);
        int d;
        repeat (n) line(-1, 1'b0, -1, 1'b0, d);
    endtask

    initial begin
        int la, lb, lc, n0, off, expt, lsk;
        repeat (4) @(negedge clk);
        chk(vreset_o == 1'b0, "R1 vreset", int'(vreset_o), 0);
        chk(field_line_o == '0, "R1 count", int'(field_line_o), 0);
        chk(range_err_o == 1'b0, "R1 flag", int'(range_err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(vreset_o == 1'b0 && range_err_o == 1'b0, "R1 after release",
            int'({vreset_o, range_err_o}), 0);
        idle(5);

        // gated mode: sweep the active edge across the line, both positions
        deint_off = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < LINE; c++) begin
                phase_late = p[0];
                off = p ? LATE : EARLY;
                n0 = ev_n;
                line(c, 1'b1, -1, 1'b0, la);
                line(-1, 1'b0, -1, 1'b0, lb);
                line(0, 1'b0, -1, 1'b0, lc);
                idle(5);
                expt = (c <= off) ? la + off : lb + off;
                chk(ev_n - n0 == 1, p ? "R3 R4 R11 count" : "R2 R4 R11 count", ev_n - n0, 1);
                chk(ev_t == expt, p ? "R3 time" : "R2 time", ev_t, expt);
                chk(int'(field_line_o) == ((c <= off) ? 7 : 6), "R7 lines",
                    int'(field_line_o), (c <= off) ? 7 : 6);
                chk(range_err_o == 1'b0, "R10 flag low", int'(range_err_o), 0);
            end
        end

        // direct mode: both polarities, every position
        deint_off = 1'b1;
        for (int pol = 0; pol < 2; pol++) begin
            edge_neg = pol[0];
            vsync = pol[0];
            for (int c = 0; c < LINE; c++) begin
                n0 = ev_n;
                line(c, ~pol[0], -1, 1'b0, la);
                line(0, pol[0], -1, 1'b0, lb);
                idle(5);
                chk(ev_n - n0 == 1, "R5 R6 R11 count", ev_n - n0, 1);
                chk(ev_t == la + c, "R5 R6 time", ev_t, la + c);
                chk(int'(field_line_o) == 6, "R7 lines", int'(field_line_o), 6);
            end
        end

        // lock range: short field and the exact minimum
        edge_neg = 1'b0;
        vsync = 1'b0;
        n0 = ev_n;
        line(3, 1'b1, -1, 1'b0, la);
        line(0, 1'b0, -1, 1'b0, lb);
        chk(ev_n - n0 == 1 && ev_t == la + 3, "R5 setup", ev_t, la + 3);
        n0 = ev_n;
        line(5, 1'b1, -1, 1'b0, lc);
        chk(ev_n == n0, "R8 early sync ignored", ev_n - n0, 0);
        chk(range_err_o == 1'b1, "R8 flag set", int'(range_err_o), 1);
        chk(int'(field_line_o) == 2, "R7 count kept", int'(field_line_o), 2);
        line(0, 1'b0, 8, 1'b1, lc);
        chk(ev_n == n0, "R8 one below minimum", ev_n - n0, 0);
        line(0, 1'b0, 8, 1'b1, lc);
        chk(ev_n == n0 + 1, "R8 at minimum accepted", ev_n - n0, 1);
        chk(ev_t == lc + 8, "R8 time", ev_t, lc + 8);
        chk(range_err_o == 1'b0, "R10 flag cleared", int'(range_err_o), 0);

        // free run to the maximum field length
        n0 = ev_n;
        lsk = 0;
        for (int k = 1; k <= MAXL; k++) begin
            line((k == 1) ? 0 : -1, 1'b0, -1, 1'b0, la);
            if (k == MAXL) lsk = la;
            if (k == MAXL - 1)
                chk(ev_n == n0, "R9 no early wrap", ev_n - n0, 0);
        end
        chk(ev_n == n0 + 1, "R9 wrap count", ev_n - n0, 1);
        chk(ev_t == lsk, "R9 wrap time", ev_t, lsk);
        chk(range_err_o == 1'b1, "R9 flag", int'(range_err_o), 1);
        chk(field_line_o == '0, "R9 count zero", int'(field_line_o), 0);
        idle(1);
        chk(int'(field_line_o) == 1, "R7 count after wrap", int'(field_line_o), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", tcyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule